// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block takes a DDR2 memory and its PHY from reset to the point where normal traffic and periodic refresh may begin. After `start`, it programs the PHY delay-locked loop in two writes. It waits for the PHY to report lock, then waits 200 µs. It then drives the memory command port through the standard mode-register, precharge and refresh sequence. Every command is followed by a wait for the controller's busy flag to drop, and some commands are also followed by a 1 µs pause.

All delays come from one down-counter whose reload values are computed from `CYC_PER_US`, the number of clock cycles per microsecond. A second counter limits how long the block waits for PHY lock. When the limit is reached, the block raises `lock_err` and stops. In SDR or plain DDR mode the whole memory sequence is skipped and `done` rises at once. `done` is the signal that lets the surrounding logic switch on periodic refresh.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: After `start` in DDR2 mode (`mem_mode`=2), `dll_cfg_wr` is high for exactly two consecutive cycles. The first carries `dll_cfg`=0x22828: bit 17 is DLL enable, bits [15:8] are a start point of 0x28 and bits [7:0] are an increment of 0x28. The second carries 0x32828, which adds bit 16, the start bit.
- R2: Lock is taken as reached when either bit of `phy_lock_bits` is 1. Bit 1 mirrors PHY status bit 31 and bit 0 mirrors status bit 30. While both bits are 0, no memory command is issued.
- R3: The first memory command is issued 200×`CYC_PER_US` cycles after the clock edge that samples lock. That is 200×`CYC_PER_US`+1 cycles after the first cycle in which lock is high.
- R4: Thirteen commands are issued in this order, with these `cmd_kind` codes:
  - wake-up (1)
  - NOP (2)
  - precharge-all (3)
  - EMR2 (7)
  - EMR3 (8)
  - EMR1 (6)
  - MR (5)
  - precharge-all (3)
  - auto-refresh (4), twice
  - MR (5)
  - EMR1 (6), twice
- R5: `cmd_word` is 0 for every command except MR and EMR1.
  - MR: burst code 3 in [2:0], CAS latency in [6:4], DLL reset at bit 8, write recovery − 1 in [11:9]. With CAS 6 and write recovery 6, the first MR is 0xB63 (DLL reset set) and the second is 0xA63.
  - EMR1 selects DLL enabled (bit 0 = 0), reduced drive (bit 1) and 75 Ω termination (bit 2), giving 0x006.
  - The first of the final two EMR1 commands adds OCD default (bits [9:7] = 7), giving 0x386. The last EMR1 carries 0x006 (OCD exit).
- R6: No command is issued while `ctl_busy` is high. `ctl_busy` is ignored in the cycle right after a command. After that, the next step is taken on the first edge that samples `ctl_busy` low.
- R7: A pause of `CYC_PER_US` cycles, inserted after busy clears, follows each of these commands:
  - the first EMR1
  - the first MR
  - the second precharge-all
  - each auto-refresh
  - the second MR
- R8: With `mem_mode` 0 (SDR) or 1 (DDR), `start` sets `done` on the next edge, with no DLL write and no command. Without `start`, `done` stays low.
- R9: If lock is not seen within `LOCK_TIMEOUT` cycles of waiting, `lock_err` rises and stays high. No further DLL write or command follows, even if lock arrives later.
- R10: After reset, all outputs are 0. `cmd_valid` is a one-cycle pulse. `done` rises when busy clears after the last command, stays high until reset, and a further `start` issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the sequence (sampled in idle) |
| mem_mode | input | 2 | 0 SDR, 1 DDR, 2 DDR2 |
| phy_lock_bits | input | 2 | PHY lock status bits (status 31, 30) |
| ctl_busy | input | 1 | Memory controller busy flag |
| dll_cfg | output | 18 | DLL control word to the PHY |
| dll_cfg_wr | output | 1 | Write strobe for `dll_cfg` |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 4 | Command code |
| cmd_word | output | 16 | Mode-register payload |
| done | output | 1 | Initialisation complete |
| lock_err | output | 1 | DLL lock timeout |

## Verification
The assertions assume the following about the controller and the inputs:
- The controller raises `ctl_busy` no later than the cycle after a command and clears it in finite time.
- `mem_mode` is held steady from `start` until `done`.
- Once PHY lock has been sampled, its later value does not matter.

The bench stays within these assumptions. It models the controller as a registered busy counter that goes high for three cycles after each strobe, and it holds the mode constant for each run. It resets the block between scenarios and raises lock well after the DLL writes.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    localparam int STEP_W    = 4;
    localparam int NUM_STEPS = 13;
    localparam int DLL_W     = 18;

    typedef enum logic [3:0] {
        CMD_NONE  = 4'd0,
        CMD_WAKE  = 4'd1,
        CMD_NOP   = 4'd2,
        CMD_PREA  = 4'd3,
        CMD_AREF  = 4'd4,
        CMD_MRS   = 4'd5,
        CMD_EMR1  = 4'd6,
        CMD_EMR2  = 4'd7,
        CMD_EMR3  = 4'd8
    } mem_cmd_e;

    typedef enum logic [1:0] {
        MODE_SDR  = 2'd0,
        MODE_DDR  = 2'd1,
        MODE_DDR2 = 2'd2
    } mem_mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DLL_ON,
        S_DLL_GO,
        S_LOCK,
        S_WAIT,
        S_ISSUE,
        S_GUARD,
        S_POLL,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        mem_cmd_e    kind;
        logic [15:0] word;
        logic        pause_after;
        logic        final_step;
    } seq_step_t;

    localparam logic [2:0] BURST_CODE_DDR2 = 3'd3;
    localparam logic [2:0] BURST_CODE_SDR  = 3'd2;
    localparam logic [7:0] DLL_START_PT    = 8'h28;
    localparam logic [7:0] DLL_STEP_INC    = 8'h28;

    // PHY DLL word: bit 17 enable, bit 16 start, [15:8] start point, [7:0] step
    function automatic logic [DLL_W-1:0] dll_word(input logic go);
        logic [DLL_W-1:0] w;
        w        = '0;
        w[17]    = 1'b1;
        w[16]    = go;
        w[15:8]  = DLL_START_PT;
        w[7:0]   = DLL_STEP_INC;
        return w;
    endfunction

    // Mode register: burst [2:0], CAS [6:4], DLL reset [8], write recovery-1 [11:9]
    function automatic logic [15:0] mr_word(input logic [2:0] cas,
                                            input logic [2:0] wr_m1,
                                            input logic       dll_rst,
                                            input logic [2:0] burst);
        logic [15:0] w;
        w        = '0;
        w[2:0]   = burst;
        w[6:4]   = cas;
        w[8]     = dll_rst;
        w[11:9]  = wr_m1;
        return w;
    endfunction

    // Extended mode 1: DLL on (bit0=0), reduced drive, 75 ohm termination, OCD field [9:7]
    function automatic logic [15:0] emr1_word(input logic ocd_default);
        logic [15:0] w;
        w        = '0;
        w[1]     = 1'b1;
        w[2]     = 1'b1;
        w[9:7]   = ocd_default ? 3'b111 : 3'b000;
        return w;
    endfunction

endpackage

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
    import ddr2_seq_pkg::*;
#(
    parameter int CAS_LAT = 6,
    parameter int WR_REC  = 6
) (
    input  logic [STEP_W-1:0] idx,
    output seq_step_t         step
);
    localparam logic [2:0] CAS3 = 3'(CAS_LAT);
    localparam logic [2:0] WRM1 = 3'(WR_REC - 1);
    localparam logic [15:0] MR_RST  = mr_word(CAS3, WRM1, 1'b1, BURST_CODE_DDR2);
    localparam logic [15:0] MR_RUN  = mr_word(CAS3, WRM1, 1'b0, BURST_CODE_DDR2);
    localparam logic [15:0] EMR_STD = emr1_word(1'b0);
    localparam logic [15:0] EMR_OCD = emr1_word(1'b1);

    always_comb begin
        step = '{kind: CMD_NONE, word: 16'h0, pause_after: 1'b0, final_step: 1'b1};
        case (idx)
            4'd0:  step = '{CMD_WAKE, 16'h0,   1'b0, 1'b0};
            4'd1:  step = '{CMD_NOP,  16'h0,   1'b0, 1'b0};
            4'd2:  step = '{CMD_PREA, 16'h0,   1'b0, 1'b0};
            4'd3:  step = '{CMD_EMR2, 16'h0,   1'b0, 1'b0};
            4'd4:  step = '{CMD_EMR3, 16'h0,   1'b0, 1'b0};
            4'd5:  step = '{CMD_EMR1, EMR_STD, 1'b1, 1'b0};
            4'd6:  step = '{CMD_MRS,  MR_RST,  1'b1, 1'b0};
            4'd7:  step = '{CMD_PREA, 16'h0,   1'b1, 1'b0};
            4'd8:  step = '{CMD_AREF, 16'h0,   1'b1, 1'b0};
            4'd9:  step = '{CMD_AREF, 16'h0,   1'b1, 1'b0};
            4'd10: step = '{CMD_MRS,  MR_RUN,  1'b1, 1'b0};
            4'd11: step = '{CMD_EMR1, EMR_OCD, 1'b0, 1'b0};
            4'd12: step = '{CMD_EMR1, EMR_STD, 1'b0, 1'b1};
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_us_timer.sv
module ddr2_us_timer #(
    parameter int CYC_PER_US = 400,
    parameter int LONG_US    = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_long,
    output logic zero
);
    localparam int LONG_CYC = LONG_US * CYC_PER_US;
    localparam int CW       = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_RELOAD  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_RELOAD = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_long ? LONG_RELOAD : SHORT_RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    assert_wait_countdown_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_long_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (load && load_long) |=> (cnt == LONG_RELOAD));

    assert_short_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (load && !load_long) |=> (cnt == SHORT_RELOAD));
endmodule

// File: rtl/ddr2_lock_watch.sv
module ddr2_lock_watch #(
    parameter int LOCK_TIMEOUT = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic [1:0] lock_bits,
    output logic       locked,
    output logic       expired
);
    localparam int TW = $clog2(LOCK_TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(LOCK_TIMEOUT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign locked  = |lock_bits;
    assign expired = arm && !locked && (cnt == LAST);

    assert_lock_count_R9: assert property (@(posedge clk) disable iff (rst)
        (arm && cnt != LAST) |=> (!arm || cnt == $past(cnt) + 1'b1));

    assert_lock_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (cnt == '0));
endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import ddr2_seq_pkg::*;
#(
    parameter int CYC_PER_US   = 400,
    parameter int LOCK_TIMEOUT = 4096,
    parameter int CAS_LAT      = 6,
    parameter int WR_REC       = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  mem_mode,
    input  logic [1:0]  phy_lock_bits,
    input  logic        ctl_busy,
    output logic [17:0] dll_cfg,
    output logic        dll_cfg_wr,
    output logic        cmd_valid,
    output logic [3:0]  cmd_kind,
    output logic [15:0] cmd_word,
    output logic        done,
    output logic        lock_err
);
    localparam int START_WAIT_US = 200;
    localparam logic [DLL_W-1:0] DLL_ON_VAL = dll_word(1'b0);
    localparam logic [DLL_W-1:0] DLL_GO_VAL = dll_word(1'b1);

    seq_state_e        st, nxt;
    logic [STEP_W-1:0] step_q, step_nxt;
    seq_step_t         cur;
    logic              tmr_load, tmr_long, tmr_zero;
    logic              lk_seen, lk_expired;

    ddr2_step_rom #(.CAS_LAT(CAS_LAT), .WR_REC(WR_REC)) u_rom (
        .idx  (step_q),
        .step (cur)
    );

    ddr2_us_timer #(.CYC_PER_US(CYC_PER_US), .LONG_US(START_WAIT_US)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .load      (tmr_load),
        .load_long (tmr_long),
        .zero      (tmr_zero)
    );

    ddr2_lock_watch #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .arm       (st == S_LOCK),
        .lock_bits (phy_lock_bits),
        .locked    (lk_seen),
        .expired   (lk_expired)
    );

    always_comb begin
        nxt      = st;
        step_nxt = step_q;
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        case (st)
            S_IDLE:
                if (start)
                    nxt = (mem_mode == MODE_DDR2) ? S_DLL_ON : S_DONE;
            S_DLL_ON: nxt = S_DLL_GO;
            S_DLL_GO: nxt = S_LOCK;
            S_LOCK: begin
                if (lk_seen) begin
                    nxt      = S_WAIT;
                    tmr_load = 1'b1;
                    tmr_long = 1'b1;
                    step_nxt = '0;
                end else if (lk_expired) begin
                    nxt = S_ERR;
                end
            end
            S_WAIT:  if (tmr_zero) nxt = S_ISSUE;
            S_ISSUE: nxt = S_GUARD;
            S_GUARD: nxt = S_POLL;
            S_POLL: begin
                if (!ctl_busy) begin
                    if (cur.final_step) begin
                        nxt = S_DONE;
                    end else begin
                        step_nxt = step_q + STEP_W'(1);
                        if (cur.pause_after) begin
                            nxt      = S_WAIT;
                            tmr_load = 1'b1;
                        end else begin
                            nxt = S_ISSUE;
                        end
                    end
                end
            end
            S_DONE:  nxt = S_DONE;
            S_ERR:   nxt = S_ERR;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            step_q <= '0;
        end else begin
            st     <= nxt;
            step_q <= step_nxt;
        end
    end

    assign dll_cfg_wr = (st == S_DLL_ON) || (st == S_DLL_GO);
    assign dll_cfg    = (st == S_DLL_ON) ? DLL_ON_VAL :
                        (st == S_DLL_GO) ? DLL_GO_VAL : '0;
    assign cmd_valid  = (st == S_ISSUE);
    assign cmd_kind   = cmd_valid ? cur.kind : CMD_NONE;
    assign cmd_word   = cmd_valid ? cur.word : 16'h0;
    assign done       = (st == S_DONE);
    assign lock_err   = (st == S_ERR);

    assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !cmd_valid && !dll_cfg_wr));

    assert_err_halt_R9: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> (lock_err && !cmd_valid && !dll_cfg_wr));

    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && lock_err));

    assert_dll_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (dll_cfg_wr && !dll_cfg[16]) |=> (dll_cfg_wr && dll_cfg == DLL_GO_VAL));

    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_POLL && ctl_busy) |=> !cmd_valid);

    assert_no_cmd_unlocked_R2: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOCK && phy_lock_bits == 2'b00) |=> !cmd_valid);
endmodule

// File: tb/sim_ddr2_pwrup_seq.sv
module sim_ddr2_pwrup_seq;
    import ddr2_seq_pkg::*;

    localparam int CPU      = 4;
    localparam int LTO      = 100;
    localparam int BUSY_LEN = 3;
    localparam int NSTEP    = 13;

    // {kind[3:0], word[15:0], pause_after}
    localparam logic [20:0] EXP_TAB [NSTEP] = '{
        {4'd1, 16'h0000, 1'b0},
        {4'd2, 16'h0000, 1'b0},
        {4'd3, 16'h0000, 1'b0},
        {4'd7, 16'h0000, 1'b0},
        {4'd8, 16'h0000, 1'b0},
        {4'd6, 16'h0006, 1'b1},
        {4'd5, 16'h0B63, 1'b1},
        {4'd3, 16'h0000, 1'b1},
        {4'd4, 16'h0000, 1'b1},
        {4'd4, 16'h0000, 1'b1},
        {4'd5, 16'h0A63, 1'b1},
        {4'd6, 16'h0386, 1'b0},
        {4'd6, 16'h0006, 1'b0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mem_mode = 2'd0;
    logic [1:0]  lock_bits = 2'b00;
    logic        ctl_busy;
    logic [17:0] dll_cfg;
    logic        dll_cfg_wr, cmd_valid, done, lock_err;
    logic [3:0]  cmd_kind;
    logic [15:0] cmd_word;

    int checks = 0, fails = 0;
    int cyc = 0;
    int bcnt = 0;
    int ndll = 0, ncmd = 0, busy_viol = 0, lock_cyc = 0;
    int          dll_cyc [0:7];
    logic [17:0] dll_v   [0:7];
    int          cmd_cyc [0:31];
    logic [3:0]  cmd_k   [0:31];
    logic [15:0] cmd_w   [0:31];

    ddr2_pwrup_seq #(.CYC_PER_US(CPU), .LOCK_TIMEOUT(LTO)) u0 (
        .clk(clk), .rst(rst), .start(start), .mem_mode(mem_mode),
        .phy_lock_bits(lock_bits), .ctl_busy(ctl_busy),
        .dll_cfg(dll_cfg), .dll_cfg_wr(dll_cfg_wr), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_word(cmd_word), .done(done), .lock_err(lock_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // controller model: busy for BUSY_LEN cycles after each command
    always @(posedge clk) begin
        if (rst) bcnt <= 0;
        else if (cmd_valid) bcnt <= BUSY_LEN;
        else if (bcnt != 0) bcnt <= bcnt - 1;
    end
    assign ctl_busy = (bcnt != 0);

    always @(negedge clk) begin
        if (!rst) begin
            if (dll_cfg_wr) begin
                if (ndll < 8) begin dll_v[ndll] = dll_cfg; dll_cyc[ndll] = cyc; end
                ndll = ndll + 1;
            end
            if (cmd_valid) begin
                if (ncmd < 32) begin
                    cmd_k[ncmd] = cmd_kind; cmd_w[ncmd] = cmd_word; cmd_cyc[ncmd] = cyc;
                end
                if (ctl_busy) busy_viol = busy_viol + 1;
                ncmd = ncmd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; lock_bits = 2'b00;
        repeat (4) @(negedge clk);
        ndll = 0; ncmd = 0; busy_viol = 0;
        rst = 1'b0;
    endtask

    task automatic kick(input logic [1:0] m);
        @(negedge clk);
        mem_mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        // reset state
        do_reset();
        @(negedge clk);
        chk(!done && !lock_err && !cmd_valid && !dll_cfg_wr, "R10", "outputs after reset",
            {done, lock_err, cmd_valid, dll_cfg_wr}, 0);

        // full DDR2 run, lock through status bit 31
        kick(2'd2);
        repeat (20) @(negedge clk);
        chk(ncmd == 0, "R2", "no command before lock", ncmd, 0);
        lock_bits = 2'b10; lock_cyc = cyc;
        wait_done(3000);
        chk(ndll == 2, "R1", "dll write count", ndll, 2);
        chk(dll_v[0] == 18'h22828, "R1", "first dll word", dll_v[0], 18'h22828);
        chk(dll_v[1] == 18'h32828, "R1", "second dll word", dll_v[1], 18'h32828);
        chk(dll_cyc[1] - dll_cyc[0] == 1, "R1", "dll writes adjacent", dll_cyc[1] - dll_cyc[0], 1);
        chk(cmd_cyc[0] - lock_cyc == 200 * CPU + 1, "R3", "lock to first command",
            cmd_cyc[0] - lock_cyc, 200 * CPU + 1);
        chk(ncmd == NSTEP, "R4", "command count", ncmd, NSTEP);
        for (int j = 0; j < NSTEP; j++) begin
            chk(cmd_k[j] == EXP_TAB[j][20:17], "R4", $sformatf("kind of step %0d", j),
                cmd_k[j], EXP_TAB[j][20:17]);
            chk(cmd_w[j] == EXP_TAB[j][16:1], "R5", $sformatf("word of step %0d", j),
                cmd_w[j], EXP_TAB[j][16:1]);
            if (j < NSTEP - 1)
                chk(cmd_cyc[j+1] - cmd_cyc[j] == BUSY_LEN + 2 + (EXP_TAB[j][0] ? CPU : 0),
                    "R7", $sformatf("gap after step %0d", j), cmd_cyc[j+1] - cmd_cyc[j],
                    BUSY_LEN + 2 + (EXP_TAB[j][0] ? CPU : 0));
        end
        chk(busy_viol == 0, "R6", "commands issued while busy", busy_viol, 0);
        chk(done == 1'b1, "R10", "done after sequence", done, 1);
        repeat (50) @(negedge clk);
        kick(2'd2);
        repeat (50) @(negedge clk);
        chk(done && ncmd == NSTEP && ndll == 2, "R10", "done sticky, restart ignored", ncmd, NSTEP);

        // DDR2 run, lock through status bit 30
        do_reset();
        kick(2'd2);
        repeat (15) @(negedge clk);
        lock_bits = 2'b01; lock_cyc = cyc;
        wait_done(3000);
        chk(cmd_cyc[0] - lock_cyc == 200 * CPU + 1, "R2", "bit30 lock to first command",
            cmd_cyc[0] - lock_cyc, 200 * CPU + 1);
        chk(done && ncmd == NSTEP, "R2", "bit30 lock completes", ncmd, NSTEP);

        // lock timeout
        do_reset();
        kick(2'd2);
        repeat (LTO + 50) @(negedge clk);
        chk(lock_err == 1'b1, "R9", "lock_err after timeout", lock_err, 1);
        chk(!done && ncmd == 0 && ndll == 2, "R9", "no progress after timeout", ncmd, 0);
        lock_bits = 2'b11;
        repeat (1000) @(negedge clk);
        chk(lock_err && !done && ncmd == 0 && ndll == 2, "R9", "halt holds after late lock", ncmd, 0);

        // SDR and DDR modes skip the sequence
        do_reset();
        mem_mode = 2'd0;
        repeat (5) @(negedge clk);
        chk(!done, "R8", "no done without start", done, 0);
        kick(2'd0);
        repeat (2) @(negedge clk);
        chk(done && ndll == 0 && ncmd == 0, "R8", "SDR goes straight to done", {done, 4'(ncmd)}, 5'h10);

        do_reset();
        kick(2'd1);
        repeat (2) @(negedge clk);
        chk(done && ndll == 0 && ncmd == 0 && !lock_err, "R8", "DDR goes straight to done",
            {done, 4'(ndll)}, 5'h10);

        summary();
        $finish;
    end
endmodule